// File: doc/BRIEF.md
# Gibbs Node Label Sampler

This block draws one new label for a single node of a grid-shaped Markov random field from the node's conditional Boltzmann distribution. The caller presents one data cost per candidate label, the current labels of the four grid neighbours and a 32-bit uniform random word, and pulses a start strobe. The block walks the candidate labels one per cycle. For each label it adds the data cost to four smoothness costs taken from a local pair table. It scales the total by a power-of-two beta and converts it to a 16-bit weight through a negative-exponential unit. It pushes the running weight sum into a FIFO. The threshold is the final sum scaled by the random fraction. The stored sums are then popped in label order until one exceeds that threshold. The chosen label is returned with a one-cycle done strobe.

The smoothness table is loaded over a simple write port before sampling starts. The label count, the cost width and the beta shift are parameters. A grid-level scheduler would place one of these blocks per node of a colour class and feed it from label and cost buffers.

Top module: `gibbs_node_sampler`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0 and label_o is 0.
- R2: The smoothness table holds one COST_W-bit entry per label pair, written at address cand*NUM_LABELS + nbr. The total cost of candidate k is data_cost_i[k*COST_W +: COST_W] plus the four entries (k, north), (k, south), (k, east) and (k, west).
- R3: The weight of exponent input x is computed as follows. Let n = x >> 8 and f = x mod 256. Let m = (f >> 4)*16 + 8, c = floor(m^3 / 1536) and p = 65536 + floor(f*f/2) - 256*f - c, limited to at most 65535. The weight is p >> n when n < 16, and 0 otherwise.
- R4: The exponent input is the total cost shifted right by BETA_SHIFT bits.
- R5: Cumulative weight sums are formed in ascending label order. The threshold is the upper 32 bits of (final sum × rand_i), with rand_i taken as an unsigned fraction.
- R6: The returned label is the lowest label whose cumulative sum is strictly greater than the threshold, or NUM_LABELS-1 if no sum is.
- R7: When the selected label is k, done_o is high for exactly one cycle, after the (NUM_LABELS+2+k)-th rising edge following the edge that accepted start_i. label_o changes only at that edge.
- R8: A start is accepted only while ready_o is 1. ready_o stays 0 from acceptance until done. Start pulses and input changes while busy have no effect on the result.
- R9: With all weights zero, the last label is returned. With rand_i = 0 and a nonzero weight for label 0, label 0 is returned. With rand_i = 32'hFFFFFFFF and a nonzero weight for the last label, the last label is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Smoothness table write enable |
| tbl_waddr_i | input | TAB_AW | Table address, cand*NUM_LABELS + nbr |
| tbl_wdata_i | input | COST_W | Table entry |
| start_i | input | 1 | Start a sample (taken while ready_o) |
| ready_o | output | 1 | Idle, a start is accepted |
| data_cost_i | input | NUM_LABELS*COST_W | Data cost per label, label 0 in the low bits |
| nbr_n_i | input | LBL_W | North neighbour label |
| nbr_s_i | input | LBL_W | South neighbour label |
| nbr_e_i | input | LBL_W | East neighbour label |
| nbr_w_i | input | LBL_W | West neighbour label |
| rand_i | input | 32 | Uniform random fraction |
| done_o | output | 1 | One-cycle result strobe |
| label_o | output | LBL_W | Sampled label |

## Verification
The hardest outcomes to provoke from the ports are the two ends of the threshold range, and the case where every weight is zero so that no comparison succeeds. The stimulus reaches them directly. rand_i is set to zero and to all ones, with costs chosen so that the relevant edge weight is nonzero. A second case drives data costs near full scale, which pushes the exponent's integer part past 15. A mid-run start pulse with altered costs and random word checks that a busy block keeps the captured operands. An asymmetric table exercises the direction of the pair addressing.

// File: rtl/gibbs_pkg.sv
package gibbs_pkg;
  localparam int FRAC_W = 8;
  localparam int EXP_W  = 16;
  localparam int SUM_W  = 32;
  localparam int RAND_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCUM, ST_THRESH, ST_SCAN} state_e;

  // cubic Taylor remainder at the centre of a 16-step fraction segment
  function automatic logic [EXP_W-1:0] nexp_corr(input int seg);
    int m;
    m = seg * 16 + 8;
    return EXP_W'((m * m * m) / 1536);
  endfunction
endpackage

// File: rtl/gibbs_cost_table.sv
module gibbs_cost_table #(
  parameter int NUM_LABELS = 4,
  parameter int COST_W     = 16,
  localparam int LBL_W  = (NUM_LABELS > 1) ? $clog2(NUM_LABELS) : 1,
  localparam int TAB_AW = $clog2(NUM_LABELS * NUM_LABELS),
  localparam int SUM4_W = COST_W + 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [TAB_AW-1:0] waddr_i,
  input  logic [COST_W-1:0] wdata_i,
  input  logic [LBL_W-1:0]  cand_i,
  input  logic [LBL_W-1:0]  nbr_i [4],
  output logic [SUM4_W-1:0] sum_o
);
  logic [COST_W-1:0] mem_q [NUM_LABELS*NUM_LABELS];
  logic [COST_W-1:0] cost [4];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < 4; g++) begin : g_rd
    assign cost[g] = mem_q[TAB_AW'(int'(cand_i) * NUM_LABELS + int'(nbr_i[g]))];
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < 4; i++) sum_o = sum_o + SUM4_W'(cost[i]);
  end
endmodule

// File: rtl/gibbs_nexp.sv
module gibbs_nexp
  import gibbs_pkg::*;
#(
  parameter int X_W = 19
) (
  input  logic [X_W-1:0]   x_i,
  output logic [EXP_W-1:0] y_o
);
  logic [FRAC_W-1:0] frac;
  logic [X_W-1:0]    ipart;
  logic [18:0]       fx, poly;
  logic [EXP_W-1:0]  mant;
  logic [EXP_W-1:0]  corr_tab [16];

  always_comb begin
    for (int s = 0; s < 16; s++) corr_tab[s] = nexp_corr(s);
  end

  always_comb begin
    frac  = x_i[FRAC_W-1:0];
    ipart = x_i >> FRAC_W;
    fx    = 19'(frac);
    poly  = 19'd65536 + ((fx * fx) >> 1) - (fx << 8) - 19'(corr_tab[frac[7:4]]);
    mant  = (poly > 19'd65535) ? 16'hFFFF : poly[15:0];
    y_o   = (ipart >= X_W'(16)) ? '0 : (mant >> ipart[3:0]);
  end
endmodule

// File: rtl/gibbs_sum_fifo.sv
module gibbs_sum_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
    end
  end

  assign head_o = mem_q[rd_q];
endmodule

// File: rtl/gibbs_node_sampler.sv
module gibbs_node_sampler
  import gibbs_pkg::*;
#(
  parameter int NUM_LABELS = 4,
  parameter int COST_W     = 16,
  parameter int BETA_SHIFT = 0,
  localparam int LBL_W  = (NUM_LABELS > 1) ? $clog2(NUM_LABELS) : 1,
  localparam int TAB_AW = $clog2(NUM_LABELS * NUM_LABELS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tbl_we_i,
  input  logic [TAB_AW-1:0]            tbl_waddr_i,
  input  logic [COST_W-1:0]            tbl_wdata_i,
  input  logic                         start_i,
  output logic                         ready_o,
  input  logic [NUM_LABELS*COST_W-1:0] data_cost_i,
  input  logic [LBL_W-1:0]             nbr_n_i,
  input  logic [LBL_W-1:0]             nbr_s_i,
  input  logic [LBL_W-1:0]             nbr_e_i,
  input  logic [LBL_W-1:0]             nbr_w_i,
  input  logic [RAND_W-1:0]            rand_i,
  output logic                         done_o,
  output logic [LBL_W-1:0]             label_o
);
  localparam int TOT_W = COST_W + 3;

  state_e                      state_q;
  logic [LBL_W-1:0]            idx_q, label_q;
  logic [SUM_W-1:0]            acc_q, thr_q, acc_nxt, head;
  logic [NUM_LABELS*COST_W-1:0] dcost_q;
  logic [LBL_W-1:0]            nbr_q [4];
  logic [RAND_W-1:0]           rand_q;
  logic                        done_q;

  logic [COST_W-1:0]  dc_k;
  logic [COST_W+1:0]  smooth_sum;
  logic [TOT_W-1:0]   total, x_beta;
  logic [EXP_W-1:0]   weight;
  logic               accept, last, hit;

  gibbs_cost_table #(.NUM_LABELS(NUM_LABELS), .COST_W(COST_W)) u_tab (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .cand_i  (idx_q),
    .nbr_i   (nbr_q),
    .sum_o   (smooth_sum)
  );

  always_comb begin
    dc_k   = dcost_q[int'(idx_q)*COST_W +: COST_W];
    total  = TOT_W'(dc_k) + TOT_W'(smooth_sum);
    x_beta = total >> BETA_SHIFT;
  end

  gibbs_nexp #(.X_W(TOT_W)) u_exp (
    .x_i (x_beta),
    .y_o (weight)
  );

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign acc_nxt = acc_q + SUM_W'(weight);
  assign last    = (idx_q == LBL_W'(NUM_LABELS-1));
  assign hit     = head > thr_q;

  gibbs_sum_fifo #(.W(SUM_W), .DEPTH(NUM_LABELS)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (accept),
    .push_i  (state_q == ST_ACCUM),
    .data_i  (acc_nxt),
    .pop_i   (state_q == ST_SCAN),
    .head_o  (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      thr_q   <= '0;
      dcost_q <= '0;
      rand_q  <= '0;
      done_q  <= 1'b0;
      label_q <= '0;
      for (int i = 0; i < 4; i++) nbr_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dcost_q  <= data_cost_i;
          rand_q   <= rand_i;
          nbr_q[0] <= nbr_n_i;
          nbr_q[1] <= nbr_s_i;
          nbr_q[2] <= nbr_e_i;
          nbr_q[3] <= nbr_w_i;
          idx_q    <= '0;
          acc_q    <= '0;
          state_q  <= ST_ACCUM;
        end
        ST_ACCUM: begin
          acc_q <= acc_nxt;
          if (last) begin
            idx_q   <= '0;
            state_q <= ST_THRESH;
          end else begin
            idx_q <= idx_q + LBL_W'(1);
          end
        end
        ST_THRESH: begin
          thr_q   <= SUM_W'((64'(acc_q) * 64'(rand_q)) >> 32);
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (hit || last) begin
            label_q <= idx_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + LBL_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign label_o = label_q;
endmodule

// File: rtl/gibbs_node_sampler_chk.sv
module gibbs_node_sampler_chk #(
  parameter int NUM_LABELS = 4,
  localparam int LBL_W = (NUM_LABELS > 1) ? $clog2(NUM_LABELS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ready_o,
  input logic             done_o,
  input logic [LBL_W-1:0] label_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o); // R8
  AST_LABEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(label_o) < NUM_LABELS)); // R6
  AST_LABEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(label_o)); // R7
endmodule

bind gibbs_node_sampler gibbs_node_sampler_chk #(.NUM_LABELS(NUM_LABELS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .label_o (label_o)
);

// File: tb/gibbs_node_sampler_bench.sv
module gibbs_node_sampler_bench;
  localparam int L  = 4;
  localparam int CW = 16;
  localparam int BS = 1;
  localparam int LW = 2;
  localparam int AW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tbl_we_i = 1'b0;
  logic [AW-1:0]   tbl_waddr_i = '0;
  logic [CW-1:0]   tbl_wdata_i = '0;
  logic            start_i = 1'b0;
  logic            ready_o;
  logic [L*CW-1:0] data_cost_i = '0;
  logic [LW-1:0]   nbr_n_i = '0, nbr_s_i = '0, nbr_e_i = '0, nbr_w_i = '0;
  logic [31:0]     rand_i = '0;
  logic            done_o;
  logic [LW-1:0]   label_o;

  int checks = 0, fails = 0;
  int tbl_m [L*L];
  int dc_m [L];
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  gibbs_node_sampler #(.NUM_LABELS(L), .COST_W(CW), .BETA_SHIFT(BS)) u_gibbs_node_sampler (
    .clk_i, .rst_ni, .tbl_we_i, .tbl_waddr_i, .tbl_wdata_i, .start_i, .ready_o,
    .data_cost_i, .nbr_n_i, .nbr_s_i, .nbr_e_i, .nbr_w_i, .rand_i, .done_o, .label_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nexp_ref(input int x); // R3
    int n, f, m, c, p;
    n = x >> 8; f = x & 255;
    m = (f >> 4) * 16 + 8;
    c = (m * m * m) / 1536;
    p = 65536 + ((f * f) >> 1) - 256 * f - c;
    if (p > 65535) p = 65535;
    if (n >= 16) return 0;
    return p >> n;
  endfunction

  function automatic int ref_label(input int nb [4], input longint unsigned r);
    longint unsigned cum [L];
    longint unsigned acc, thr;
    acc = 0;
    for (int k = 0; k < L; k++) begin
      int tot;
      tot = dc_m[k];
      for (int d = 0; d < 4; d++) tot += tbl_m[k*L + nb[d]]; // R2
      acc += longint'(nexp_ref(tot >> BS)); // R4
      cum[k] = acc;
    end
    thr = (acc * r) >> 32; // R5
    for (int k = 0; k < L; k++) if (cum[k] > thr) return k; // R6
    return L - 1;
  endfunction

  task automatic load_table(input int mode);
    for (int a = 0; a < L; a++)
      for (int b = 0; b < L; b++) begin
        @(negedge clk_i);
        tbl_m[a*L+b] = (mode == 0) ? ((a > b ? a - b : b - a) * 64) : (a * 40 + b * 7);
        tbl_we_i    = 1'b1;
        tbl_waddr_i = AW'(a*L + b);
        tbl_wdata_i = CW'(tbl_m[a*L+b]);
      end
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic run_case(input int nb [4], input logic [31:0] r, input bit poke, output int got);
    int exp_k, lat;
    exp_k = ref_label(nb, longint'(r));
    got = -1;
    @(negedge clk_i);
    for (int k = 0; k < L; k++) data_cost_i[k*CW +: CW] = CW'(dc_m[k]);
    nbr_n_i = LW'(nb[0]); nbr_s_i = LW'(nb[1]);
    nbr_e_i = LW'(nb[2]); nbr_w_i = LW'(nb[3]);
    rand_i = r; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = L + 2 + exp_k;
    for (int j = 1; j <= lat; j++) begin
      @(negedge clk_i);
      if (poke && j == 2) begin // R8: must be ignored
        start_i = 1'b1; rand_i = ~r; data_cost_i = ~data_cost_i;
        nbr_n_i = ~nbr_n_i;
      end else begin
        start_i = 1'b0;
      end
      check(done_o == (j == lat), "R7 done timing", int'(done_o), int'(j == lat));
      check(ready_o == (j == lat), "R8 ready", int'(ready_o), int'(j == lat));
      if (j == lat) begin
        got = int'(label_o);
        check(label_o == LW'(exp_k), "R6 label", int'(label_o), exp_k);
      end
    end
    start_i = 1'b0;
    @(negedge clk_i);
    check(!done_o && label_o == LW'(exp_k), "R7 hold", int'(label_o), exp_k);
  endtask

  initial begin
    int nb [4];
    int got;
    int s;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o && !done_o && label_o == '0, "R1 reset", int'({ready_o, done_o, label_o}), 8);

    load_table(0);
    dc_m = '{0, 100, 300, 600};
    nb = '{0, 0, 0, 0};
    run_case(nb, 32'h0, 1'b0, got);
    check(got == 0, "R9 zero threshold", got, 0);
    run_case(nb, 32'hFFFF_FFFF, 1'b0, got);
    check(got == L-1, "R9 max threshold", got, L-1);
    run_case(nb, 32'h8000_0000, 1'b0, got);

    dc_m = '{500, 20, 20, 900};
    nb = '{1, 2, 3, 0};
    run_case(nb, 32'h4000_0000, 1'b0, got);

    dc_m = '{65535, 65535, 65535, 65535};
    run_case(nb, 32'h1234_5678, 1'b0, got);
    check(got == L-1, "R9 zero weights", got, L-1);

    load_table(1); // asymmetric pairs for R2
    dc_m = '{40, 10, 200, 5};
    nb = '{3, 0, 2, 1};
    run_case(nb, 32'hC000_0000, 1'b1, got);

    s = 7;
    for (int t = 0; t < 10; t++) begin
      for (int k = 0; k < L; k++) begin
        s = s * 1103515245 + 12345;
        dc_m[k] = (s >>> 8) & 1023;
      end
      for (int d = 0; d < 4; d++) begin
        s = s * 1103515245 + 12345;
        nb[d] = (s >>> 16) & 3;
      end
      s = s * 1103515245 + 12345;
      run_case(nb, 32'(s), t[0], got);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule